// File: doc/BRIEF.md
# Word-Wide CRC-32 Fold Engine

This block advances a 32-bit CRC state over up to eight message bytes in one reduction. It does not shift bits through a register one at a time and it uses no lookup table. The state and the bytes are folded into one 64-bit word. Two carry-less multiplies then reduce that word: the first uses a fixed Barrett quotient for the chosen polynomial, and the second uses the polynomial itself. The block offers three polynomials. Two are reflected (LSB-first) polynomials: the common CRC-32 and the Castagnoli CRC-32C. The third is the MSB-first CRC-32.

A caller splits a message into three parts: a short head of up to seven bytes that brings the stream to a word boundary, a run of whole 8-byte words, and a tail of the leftover bytes. It feeds each part through the same port, one update at a time, and passes the previous result back in as the next state. Each partial word is folded by rules that depend on the mode and on the byte count, so head and tail bytes give the same state as a byte-serial register would.

The engine has two pipeline registers. The first holds the output of the quotient multiply and the second holds the final CRC. A result therefore appears two clock edges after it is requested, together with a one-cycle done pulse. No initial value and no final inversion are applied: the block works on the raw state.

Top module: `crc_bw_engine`

## Requirements
- R1: With `in_mode` = 0 the update equals a reflected byte-serial CRC with polynomial 0xEDB88320. Each byte is XORed into state bits 7:0 and then shifted right eight times. Message byte k sits in `in_data[8k+7:8k]`, and byte 0 is processed first.
- R2: With `in_mode` = 1 the update is the same reflected byte-serial computation with polynomial 0x82F63B78.
- R3: With `in_mode` = 2 the update equals an MSB-first byte-serial CRC with polynomial 0x04C11DB7. Each byte is XORed into state bits 31:24 and then shifted left eight times, byte 0 first. `in_mode` = 3 gives the same result as `in_mode` = 2.
- R4: `in_len_m1` holds the byte count minus one (0 means 1 byte, 7 means 8 bytes). Bytes k > `in_len_m1` have no effect on the result.
- R5: When `in_valid` is high at a rising edge, `out_done` is high for exactly the cycle that follows the next rising edge, and `out_crc` carries the result in that cycle. `out_done` is never high without such a request.
- R6: `out_crc` keeps its value in every cycle in which `out_done` is low.
- R7: A synchronous active-high `rst` clears `out_crc` to 0 and `out_done` to 0.
- R8: Feeding a message as a head, whole words and a tail, with each result passed back as the next state, gives the same CRC as feeding it byte by byte in every mode. For the bytes "123456789" with an all-ones start, the results are 0xCBF43926 (mode 0) and 0xE3069283 (mode 1) after a final inversion, and 0x0376E6E7 (mode 2) with no inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for one update |
| in_crc | input | 32 | Current CRC state |
| in_data | input | 64 | Message bytes, byte k at bits 8k+7:8k |
| in_len_m1 | input | 3 | Number of valid bytes minus one |
| in_mode | input | 2 | 0 reflected CRC-32, 1 reflected CRC-32C, 2 or 3 MSB-first CRC-32 |
| out_crc | output | 32 | Updated CRC state |
| out_done | output | 1 | One-cycle pulse marking a new `out_crc` |

## Verification
The sweep covers every byte count from one to eight in every mode. These counts matter because the state is folded differently below and above four bytes. A design that mishandled the leftover state for short words would fail only at counts one to three, and an off-by-one shift would fail at a single count. The unused upper bytes are filled with random values, so a missing byte mask shows up as a mismatch. Chained head/word/tail runs and the standard check strings would expose a wrong quotient constant, a missing one-bit realignment in the reflected path, or a byte-order swap in the MSB-first path. The done pulse is checked before, at and after its expected cycle, which catches a pipeline one stage too short or too long.

// File: rtl/crc_bw_pkg.sv
package crc_bw_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned CRC_W  = 32;
    localparam int unsigned BYTES  = WORD_W / 8;
    localparam int unsigned CNT_W  = $clog2(BYTES);
    localparam int unsigned SH_W   = $clog2(WORD_W) + 1;

    // Barrett quotients floor(x^96 / P) with the x^64 term dropped
    localparam logic [WORD_W-1:0] QT_REFL_CRC32  = 64'h5a72d812fb808b20;
    localparam logic [WORD_W-1:0] QT_REFL_CRC32C = 64'ha434f61c6f5389f8;
    localparam logic [WORD_W-1:0] QT_MSB_CRC32   = 64'h04d101df481b4e5a;

    localparam logic [CRC_W-1:0] POLY_REFL_CRC32  = 32'hEDB88320;
    localparam logic [CRC_W-1:0] POLY_REFL_CRC32C = 32'h82F63B78;
    localparam logic [CRC_W-1:0] POLY_MSB_CRC32   = 32'h04C11DB7;

    typedef enum logic [1:0] {
        MODE_REFL_CRC32  = 2'd0,
        MODE_REFL_CRC32C = 2'd1,
        MODE_MSB_CRC32   = 2'd2,
        MODE_MSB_ALIAS   = 2'd3
    } crc_mode_e;

    typedef struct packed {
        logic              msb_first;
        logic [WORD_W-1:0] qt;
        logic [CRC_W-1:0]  poly;
    } mode_cfg_t;

    // Folded word ready for the quotient multiply
    typedef struct packed {
        logic              msb_first;
        logic [CRC_W-1:0]  poly;
        logic [WORD_W-1:0] qt;
        logic [WORD_W-1:0] s;
        logic [CRC_W-1:0]  resid;
    } prep_t;

    // Registered state between the two multiplies
    typedef struct packed {
        logic              msb_first;
        logic [CRC_W-1:0]  poly;
        logic [WORD_W-1:0] t;
        logic [CRC_W-1:0]  resid;
    } mid_t;

    function automatic mode_cfg_t mode_cfg(input logic [1:0] mode);
        mode_cfg_t c;
        case (crc_mode_e'(mode))
            MODE_REFL_CRC32:  c = '{msb_first: 1'b0, qt: QT_REFL_CRC32,  poly: POLY_REFL_CRC32};
            MODE_REFL_CRC32C: c = '{msb_first: 1'b0, qt: QT_REFL_CRC32C, poly: POLY_REFL_CRC32C};
            default:          c = '{msb_first: 1'b1, qt: QT_MSB_CRC32,   poly: POLY_MSB_CRC32};
        endcase
        return c;
    endfunction

    // Full carry-less product of two words
    function automatic logic [2*WORD_W-1:0] clmul_full(input logic [WORD_W-1:0] a,
                                                        input logic [WORD_W-1:0] b);
        logic [2*WORD_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (b[i]) acc = acc ^ ({{WORD_W{1'b0}}, a} << i);
        end
        return acc;
    endfunction

    // One word-wide window of the product, starting at bit sh
    function automatic logic [WORD_W-1:0] clmul_win(input logic [WORD_W-1:0] a,
                                                     input logic [WORD_W-1:0] b,
                                                     input int unsigned sh);
        return WORD_W'(clmul_full(a, b) >> sh);
    endfunction

endpackage

// File: rtl/crc_bw_prep.sv
module crc_bw_prep
    import crc_bw_pkg::*;
(
    input  logic [CRC_W-1:0]  crc,
    input  logic [WORD_W-1:0] data,
    input  logic [CNT_W-1:0]  len_m1,
    input  logic [1:0]        mode,
    output prep_t             prep
);

    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] swapped;

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        assign masked[8*k +: 8] = (CNT_W'(k) <= len_m1) ? data[8*k +: 8] : 8'h00;
        assign swapped[8*(BYTES-1-k) +: 8] = masked[8*k +: 8];
    end

    always_comb begin
        logic [CNT_W:0]    nbytes;
        logic [SH_W-1:0]   nbits;
        logic [SH_W-1:0]   gap;
        logic              short_word;
        mode_cfg_t         cfg;
        logic [WORD_W-1:0] s;
        logic [CRC_W-1:0]  resid;

        nbytes     = (CNT_W+1)'(len_m1) + (CNT_W+1)'(1);
        nbits      = SH_W'(nbytes) << 3;
        gap        = SH_W'(WORD_W) - nbits;
        short_word = nbits < SH_W'(CRC_W);
        cfg        = mode_cfg(mode);

        if (!cfg.msb_first) begin
            // bytes sit at the top of the word, state aligned with them
            s     = (masked ^ WORD_W'(crc)) << gap;
            resid = short_word ? (crc >> nbits) : '0;
        end else begin
            // bytes packed first-most-significant into the low bits
            s = swapped >> gap;
            if (short_word) begin
                s     = s ^ WORD_W'(crc >> (SH_W'(CRC_W) - nbits));
                resid = crc << nbits;
            end else begin
                s     = s ^ (WORD_W'(crc) << (nbits - SH_W'(CRC_W)));
                resid = '0;
            end
        end

        prep = '{msb_first: cfg.msb_first, poly: cfg.poly, qt: cfg.qt, s: s, resid: resid};
    end

endmodule

// File: rtl/crc_bw_quot_stage.sv
module crc_bw_quot_stage
    import crc_bw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  prep_t in_prep,
    output logic  mid_valid,
    output mid_t  mid
);

    mid_t mid_d;

    always_comb begin
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] hi;
        lo = clmul_win(in_prep.s, in_prep.qt, 0);
        hi = clmul_win(in_prep.s, in_prep.qt, WORD_W);
        mid_d.msb_first = in_prep.msb_first;
        mid_d.poly      = in_prep.poly;
        mid_d.resid     = in_prep.resid;
        // reflected: high part recovered from the low product moved up one bit
        mid_d.t = in_prep.msb_first ? (hi ^ in_prep.s) : ((lo << 1) ^ in_prep.s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_valid <= 1'b0;
            mid       <= '0;
        end else begin
            mid_valid <= in_valid;
            if (in_valid) mid <= mid_d;
        end
    end

endmodule

// File: rtl/crc_bw_poly_stage.sv
module crc_bw_poly_stage
    import crc_bw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mid_valid,
    input  mid_t             mid,
    output logic [CRC_W-1:0] crc,
    output logic             done
);

    logic [CRC_W-1:0] crc_d;

    always_comb begin
        logic [WORD_W-1:0] pw;
        logic [CRC_W-1:0]  red;
        pw = WORD_W'(mid.poly);
        // reflected result lives at product bits 94:63, MSB-first at 31:0
        red   = mid.msb_first ? CRC_W'(clmul_win(mid.t, pw, 0))
                              : CRC_W'(clmul_win(mid.t, pw, WORD_W - 1));
        crc_d = red ^ mid.resid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc  <= '0;
            done <= 1'b0;
        end else begin
            done <= mid_valid;
            if (mid_valid) crc <= crc_d;
        end
    end

endmodule

// File: rtl/crc_bw_engine.sv
module crc_bw_engine
    import crc_bw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [CRC_W-1:0]    in_crc,
    input  logic [WORD_W-1:0]   in_data,
    input  logic [CNT_W-1:0]    in_len_m1,
    input  logic [1:0]          in_mode,
    output logic [CRC_W-1:0]    out_crc,
    output logic                out_done
);

    prep_t prep;
    mid_t  mid;
    logic  mid_valid;

    crc_bw_prep u_prep (
        .crc    (in_crc),
        .data   (in_data),
        .len_m1 (in_len_m1),
        .mode   (in_mode),
        .prep   (prep)
    );

    crc_bw_quot_stage u_quot (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_prep   (prep),
        .mid_valid (mid_valid),
        .mid       (mid)
    );

    crc_bw_poly_stage u_poly (
        .clk       (clk),
        .rst       (rst),
        .mid_valid (mid_valid),
        .mid       (mid),
        .crc       (out_crc),
        .done      (out_done)
    );

endmodule

// File: rtl/crc_bw_engine_chk.sv
module crc_bw_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] out_crc,
    input logic        out_done
);

    // cycles since reset, saturating, to keep $past inside the post-reset window
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R5: a request yields done two edges later
    a_r5_done_after_valid: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_done);

    // R5: done always has a request two edges back
    a_r5_done_has_cause: assert property (@(posedge clk) disable iff (rst)
        (out_done && since_rst >= 2'd2) |-> $past(in_valid, 2));

    // R6: result is held while done is low
    a_r6_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!out_done && since_rst >= 2'd1) |-> $stable(out_crc));

    // R7: reset clears both outputs
    a_r7_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_done && out_crc == 32'h0));

endmodule

bind crc_bw_engine crc_bw_engine_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .out_crc  (out_crc),
    .out_done (out_done)
);

// File: tb/crc_bw_engine_tb_top.sv
module crc_bw_engine_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_crc = '0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_len_m1 = '0;
    logic [1:0]  in_mode = '0;
    logic [31:0] out_crc;
    logic        out_done;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    crc_bw_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_crc    (in_crc),
        .in_data   (in_data),
        .in_len_m1 (in_len_m1),
        .in_mode   (in_mode),
        .out_crc   (out_crc),
        .out_done  (out_done)
    );

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // byte-serial reference register
    function automatic logic [31:0] ref_byte(input logic [1:0] m, input logic [31:0] c,
                                              input logic [7:0] b);
        logic [31:0] p;
        logic [31:0] r;
        r = c;
        if (!m[1]) begin
            p = m[0] ? 32'h82F63B78 : 32'hEDB88320;
            r = r ^ {24'h0, b};
            for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ p) : (r >> 1);
        end else begin
            r = r ^ {b, 24'h0};
            for (int i = 0; i < 8; i++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_word(input logic [1:0] m, input logic [31:0] c,
                                              input logic [63:0] d, input int n);
        logic [31:0] r;
        r = c;
        for (int k = 0; k < n; k++) r = ref_byte(m, r, d[8*k +: 8]);
        return r;
    endfunction

    // one request; done checked before, at and after its cycle
    task automatic run_op(input logic [1:0] m, input logic [31:0] c, input logic [63:0] d,
                          input int n, output logic [31:0] res);
        logic [31:0] held;
        @(negedge clk);
        in_valid  = 1'b1;
        in_mode   = m;
        in_crc    = c;
        in_data   = d;
        in_len_m1 = 3'(n - 1);
        @(negedge clk);
        in_valid  = 1'b0;
        in_data   = {$urandom, $urandom};
        in_crc    = $urandom;
        check("R5 done early", {31'h0, out_done}, 32'h0);
        @(negedge clk);
        check("R5 done on time", {31'h0, out_done}, 32'h1);
        res  = out_crc;
        held = out_crc;
        @(negedge clk);
        check("R5 done single", {31'h0, out_done}, 32'h0);
        check("R6 hold", out_crc, held);
    endtask

    task automatic feed(input logic [1:0] m, inout logic [31:0] c,
                        input logic [7:0] msg[32], input int off, input int n);
        logic [63:0] d;
        logic [31:0] r;
        d = {$urandom, $urandom};
        for (int k = 0; k < n; k++) d[8*k +: 8] = msg[off + k];
        run_op(m, c, d, n, r);
        c = r;
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] r2;
        logic [31:0] c;
        logic [31:0] sc;
        logic [63:0] d;
        logic [7:0]  msg[32];

        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 reset crc", out_crc, 32'h0);
        check("R7 reset done", {31'h0, out_done}, 32'h0);
        rst = 1'b0;

        // R1 R2 R3 R4: sweep every mode and count, garbage in unused bytes
        for (int m = 0; m < 4; m++) begin
            for (int n = 1; n <= 8; n++) begin
                for (int t = 0; t < 40; t++) begin
                    c = (t == 0) ? 32'h0 : (t == 1) ? 32'hFFFFFFFF : $urandom;
                    d = {$urandom, $urandom};
                    run_op(2'(m), c, d, n, r);
                    case (m)
                        0: check("R1 refl crc32", r, ref_word(2'(m), c, d, n));
                        1: check("R2 refl crc32c", r, ref_word(2'(m), c, d, n));
                        2: check("R3 msb crc32", r, ref_word(2'(m), c, d, n));
                        default: check("R3 mode3 alias", r, ref_word(2'd2, c, d, n));
                    endcase
                end
            end
        end

        // R4: unused bytes changed, result must not move
        for (int m = 0; m < 3; m++) begin
            for (int n = 1; n < 8; n++) begin
                c = $urandom;
                d = {$urandom, $urandom};
                run_op(2'(m), c, d, n, r);
                d = d ^ ({64{1'b1}} << (8 * n));
                run_op(2'(m), c, d, n, r2);
                check("R4 unused bytes ignored", r2, r);
            end
        end

        // R8: check strings
        msg = '{default: 8'h00};
        for (int k = 0; k < 9; k++) msg[k] = 8'h31 + 8'(k);
        for (int m = 0; m < 3; m++) begin
            c = 32'hFFFFFFFF;
            feed(2'(m), c, msg, 0, 8);
            feed(2'(m), c, msg, 8, 1);
            case (m)
                0: check("R8 check value crc32", ~c, 32'hCBF43926);
                1: check("R8 check value crc32c", ~c, 32'hE3069283);
                default: check("R8 check value msb", c, 32'h0376E6E7);
            endcase
        end

        // R8: head 5, two words, tail 2 against byte-serial
        for (int m = 0; m < 3; m++) begin
            for (int k = 0; k < 32; k++) msg[k] = 8'($urandom);
            c  = $urandom;
            sc = c;
            for (int k = 0; k < 23; k++) sc = ref_byte(2'(m), sc, msg[k]);
            feed(2'(m), c, msg, 0, 5);
            feed(2'(m), c, msg, 5, 8);
            feed(2'(m), c, msg, 13, 8);
            feed(2'(m), c, msg, 21, 2);
            check("R8 chained message", c, sc);
        end

        // R7: reset in mid-run clears result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset crc mid-run", out_crc, 32'h0);
        check("R7 reset done mid-run", {31'h0, out_done}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule